// File: doc/BRIEF.md
# Programmable Clock Output Stage

This block fans one fast input clock out to several output clocks. There is a full-rate differential pair and a single-ended output that runs at the full rate or at a scaled-down rate. There is also a half-rate differential pair, a single-ended half-rate output and a general function output. The function output repeats a plain input pin.

An 8-bit control byte is sampled on every rising edge of the input clock. It holds one drive enable per output, an inversion bit for the half-rate clock and a 2-bit power-of-two ratio for the scaled output. An output whose enable is clear floats at high impedance. Reset clears the byte, so every output starts floating.

Top module: `clk_out_stage`

## Requirements
- R1: The control byte is registered on each rising edge of `clk_in`. The register holds 0x00 while `rst` is high, so all seven outputs are high impedance during reset and until a nonzero byte has been registered.
- R2: Each enable bit is 1 to drive its output and 0 to leave the output at high impedance. Bit 0 controls `fr_p`/`fr_n`. Bit 1 controls `fr_se`. Bit 2 controls `hr_p`/`hr_n`. Bit 3 controls `hr_se`. Bit 4 controls `fn_out`.
- R3: The half-rate clock is low after reset and toggles on every rising edge of `clk_in`. When registered bit 5 is 1, `hr_p` and `hr_se` carry the inverted clock. `hr_n` is always the complement of `hr_p`.
- R4: Registered bits 7:6 set the ratio of `fr_se`. Code 00 divides by 1, code 01 by 2, code 10 by 4 and code 11 by 8. Over 64 input cycles, `fr_se` shows 64, 32, 16 or 8 rising edges.
- R5: The scaled output is taken from a 3-bit counter that counts input rising edges from 0 after reset. Code k (k>0) selects counter bit k-1. A new ratio code takes effect only on the edge where the counter wraps from 7 to 0.
- R6: When enabled, `fr_p` follows `clk_in` and `fr_n` is its complement.
- R7: When enabled, `fn_out` follows `fn_in` without any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst | input | 1 | Active-high synchronous reset |
| ctrl | input | 8 | Control byte: enables [4:0], half-rate invert [5], scale code [7:6] |
| fn_in | input | 1 | Source of the function output |
| fr_p | output | 1 | Full-rate clock, true side |
| fr_n | output | 1 | Full-rate clock, complement side |
| fr_se | output | 1 | Single-ended full-rate clock after the scaler |
| hr_p | output | 1 | Half-rate clock, true side |
| hr_n | output | 1 | Half-rate clock, complement side |
| hr_se | output | 1 | Single-ended half-rate clock |
| fn_out | output | 1 | Function output |

## Verification
A new control byte reaches the enables, the invert bit and the pass-through outputs one rising edge after it is applied. A new ratio code waits further, for the next wrap of the counter, which comes between one and eight edges later. The bench keeps a reference state that it advances on each rising edge from the requirements alone: an edge count since reset, the registered byte and the active ratio. It compares every output against that state one nanosecond after each falling edge, when all the registers have settled. Ratio edge counts are taken only after at least ten edges have passed since the code changed.

// File: rtl/clk_out_stage.sv
module clk_out_stage #(
  parameter int SCL_W = 2
) (
  input  logic clk_in,
  input  logic rst,
  input  logic [7:0] ctrl,
  input  logic fn_in,
  output wire  fr_p,
  output wire  fr_n,
  output wire  fr_se,
  output wire  hr_p,
  output wire  hr_n,
  output wire  hr_se,
  output wire  fn_out
);
  localparam int CNT_W = (1 << SCL_W) - 1;

  logic [7:0]       ctrl_q;
  logic             tog;
  logic [CNT_W-1:0] cnt;
  logic [SCL_W-1:0] sel_q;
  logic             half, scaled;

  always_ff @(posedge clk_in) begin
    if (rst) begin
      ctrl_q <= '0;
      tog    <= 1'b0;
      cnt    <= '0;
      sel_q  <= '0;
    end else begin
      ctrl_q <= ctrl;
      tog    <= ~tog;
      cnt    <= cnt + 1'b1;
      if (&cnt) sel_q <= ctrl_q[7 -: SCL_W];
    end
  end

  assign half   = tog ^ ctrl_q[5];
  assign scaled = (sel_q == '0) ? clk_in : cnt[sel_q - 1'b1];

  assign fr_p   = ctrl_q[0] ? clk_in : 1'bz;
  assign fr_n   = ctrl_q[0] ? ~clk_in : 1'bz;
  assign fr_se  = ctrl_q[1] ? scaled : 1'bz;
  assign hr_p   = ctrl_q[2] ? half : 1'bz;
  assign hr_n   = ctrl_q[2] ? ~half : 1'bz;
  assign hr_se  = ctrl_q[3] ? half : 1'bz;
  assign fn_out = ctrl_q[4] ? fn_in : 1'bz;
endmodule

// File: rtl/clk_out_stage_chk.sv
module clk_out_stage_chk #(
  parameter int SCL_W = 2,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       ctrl,
  input logic [7:0]       ctrl_q,
  input logic             tog,
  input logic [CNT_W-1:0] cnt,
  input logic [SCL_W-1:0] sel_q
);
  p_ctrl_load_r1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ctrl_q == $past(ctrl));

  p_half_toggle_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> tog != $past(tog));

  p_cnt_step_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> cnt == CNT_W'($past(cnt) + 1'b1));

  p_sel_wrap_only_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && cnt != '0) |-> $stable(sel_q));
endmodule

bind clk_out_stage clk_out_stage_chk #(.SCL_W(SCL_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk_in), .rst(rst), .ctrl(ctrl), .ctrl_q(ctrl_q),
  .tog(tog), .cnt(cnt), .sel_q(sel_q)
);

// File: tb/test_clk_out_stage.sv
module test_clk_out_stage;
  logic clk_in = 1'b0;
  logic rst = 1'b1;
  logic [7:0] ctrl = 8'h00;
  logic fn_in = 1'b0;
  int tests = 0, fails = 0;

  always #5 clk_in = ~clk_in;

  wire u_fp, u_fn, u_fse, u_hp, u_hn, u_hse, u_fo;
  wire d_fp, d_fn, d_fse, d_hp, d_hn, d_hse, d_fo;
  pullup(u_fp); pullup(u_fn); pullup(u_fse); pullup(u_hp);
  pullup(u_hn); pullup(u_hse); pullup(u_fo);
  pulldown(d_fp); pulldown(d_fn); pulldown(d_fse); pulldown(d_hp);
  pulldown(d_hn); pulldown(d_hse); pulldown(d_fo);

  clk_out_stage i_clk_out_stage (
    .clk_in(clk_in), .rst(rst), .ctrl(ctrl), .fn_in(fn_in),
    .fr_p(u_fp), .fr_n(u_fn), .fr_se(u_fse), .hr_p(u_hp),
    .hr_n(u_hn), .hr_se(u_hse), .fn_out(u_fo));

  clk_out_stage i_clk_out_stage_dn (
    .clk_in(clk_in), .rst(rst), .ctrl(ctrl), .fn_in(fn_in),
    .fr_p(d_fp), .fr_n(d_fn), .fr_se(d_fse), .hr_p(d_hp),
    .hr_n(d_hn), .hr_se(d_hse), .fn_out(d_fo));

  // reference state advanced from the requirements
  int unsigned n_edges = 0;
  logic [7:0] m_ctrl = 8'h00;
  logic [1:0] m_sel = 2'b00;
  always @(posedge clk_in) begin
    if (rst) begin
      n_edges <= 0; m_ctrl <= 8'h00; m_sel <= 2'b00;
    end else begin
      n_edges <= n_edges + 1;
      m_ctrl  <= ctrl;
      if (n_edges % 8 == 7) m_sel <= m_ctrl[7:6];
    end
  end

  bit cnt_on = 0;
  int edge_cnt = 0;
  always @(posedge u_fse) if (cnt_on) edge_cnt++;

  function automatic logic exp_scaled(int unsigned n, logic [1:0] s);
    if (s == 2'b00) return 1'b0;
    return 1'((n >> (s - 1)) & 1);
  endfunction

  task automatic chk(string req, string nm, logic up, logic dn, logic en, logic ex);
    tests++;
    if (!en) begin
      if (!(up === 1'b1 && dn === 1'b0)) begin
        fails++;
        $display("FAIL %s %s: expected Z, got up=%b dn=%b", req, nm, up, dn);
      end
    end else if (!(up === ex && dn === ex)) begin
      fails++;
      $display("FAIL %s %s: got up=%b dn=%b expected %b", req, nm, up, dn, ex);
    end
  endtask

  task automatic check_all(string tag);
    logic h;
    h = n_edges[0] ^ m_ctrl[5];
    chk({tag, " R2 R6"}, "fr_p",  u_fp,  d_fp,  m_ctrl[0], clk_in);
    chk({tag, " R2 R6"}, "fr_n",  u_fn,  d_fn,  m_ctrl[0], ~clk_in);
    chk({tag, " R2 R5"}, "fr_se", u_fse, d_fse, m_ctrl[1], exp_scaled(n_edges, m_sel));
    chk({tag, " R2 R3"}, "hr_p",  u_hp,  d_hp,  m_ctrl[2], h);
    chk({tag, " R2 R3"}, "hr_n",  u_hn,  d_hn,  m_ctrl[2], ~h);
    chk({tag, " R2 R3"}, "hr_se", u_hse, d_hse, m_ctrl[3], h);
    chk({tag, " R2 R7"}, "fn_out", u_fo, d_fo,  m_ctrl[4], fn_in);
  endtask

  task automatic step();
    @(negedge clk_in); #1;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1523));
    ctrl = 8'hFF;
    repeat (3) step();
    check_all("R1 reset");
    rst = 1'b0;
    ctrl = 8'h00;
    step();
    check_all("R1 after reset");

    // directed ratio edge counts, R4
    for (int code = 0; code < 4; code++) begin
      ctrl = {2'(code), 6'b00_1111};
      repeat (12) step();
      edge_cnt = 0; cnt_on = 1;
      repeat (64) step();
      cnt_on = 0;
      tests++;
      if (edge_cnt != (64 >> code)) begin
        fails++;
        $display("FAIL R4 code %0d: got %0d edges expected %0d", code, edge_cnt, 64 >> code);
      end
      check_all("R4");
    end

    // directed: invert flip and ratio change mid-count, R3 R5
    ctrl = 8'b1110_1111; step(); check_all("R3 invert");
    ctrl = 8'b0100_1111;
    for (int i = 0; i < 12; i++) begin step(); check_all("R5 switch"); end

    // random phase
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 3) == 0) ctrl = 8'($urandom);
      fn_in = 1'($urandom);
      step();
      check_all("rand");
    end

    // all disabled again
    ctrl = 8'h00; step(); step(); check_all("R2 disable");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule